// File: doc/BRIEF.md
# Flash Program/Erase Status Poller

This engine runs on the host side of an external parallel flash. Once software or a sequencer has issued a program or erase command, a single `start` pulse hands the poller a verify address, an expected byte and a method. The poller then reads the status byte at that address over a simple request/acknowledge read port until it can decide whether the operation completed. For a byte program the verify address is the byte being written and the expected byte is the programmed value. For a sector erase it is any address inside the sector, and for a whole-array erase any address will do. For both erase kinds the expected byte has bit 7 set, because erased cells read as ones.

Two methods are offered. In the data-compare method (`poll_mode` = 0), bit 7 of each status read is compared with bit 7 of the expected byte. In the toggle method (`poll_mode` = 1), bit 6 is compared between consecutive reads; while the flash is busy that bit flips on every read. In both methods, bit 5 of the status byte is the device's own time-limit flag. When it appears, the poller takes one final look (one read in the data-compare method, a fresh pair of reads in the toggle method) before it declares failure, because the decisive bit may settle in the same read in which bit 5 rises. An internal read budget guarantees that the engine always finishes, even if the device never answers conclusively.

The controller has five states:
- **IDLE**: waits for `start`.
- **POLL**: the main read loop.
- **RECHK_A**: the first read after bit 5 was seen.
- **RECHK_B**: the second read of the toggle pair.
- **REPORT**: a one-cycle result state.

Its transitions are:
- *launch*: IDLE→POLL on `start`.
- *settle*: POLL→REPORT with pass.
- *retry*: POLL→POLL.
- *limit*: POLL→RECHK_A on bit 5.
- *exhaust*: POLL→REPORT with fail once the budget is spent.
- *recheck*: RECHK_A→REPORT in data mode.
- *pair*: RECHK_A→RECHK_B in toggle mode.
- *final*: RECHK_B→REPORT.
- *release*: REPORT→IDLE.

Top module: `flash_status_poller`

## Requirements
- R1: After reset `rd_req`, `done`, `pass` and `fail` are all 0.
- R2: On `start` in IDLE the address and expected byte are captured. `rd_req` rises in the following cycle, and `rd_addr` carries the captured address, unchanged, for every read of that operation.
- R3: Data-compare mode: an acknowledged read whose bit 7 equals bit 7 of the expected byte ends the operation with pass. `done` is high in the cycle after the acknowledge.
- R4: Data-compare mode: a read whose bit 7 differs and whose bit 5 is 0 causes another read.
- R5: Data-compare mode: a read whose bit 7 differs and whose bit 5 is 1 causes exactly one further read. Pass is reported if bit 7 of that read matches; otherwise fail is reported.
- R6: Toggle mode: the first read only provides a reference. Every later read whose bit 6 equals bit 6 of the read before it ends with pass.
- R7: Toggle mode: a read whose bit 6 differs from the previous read and whose bit 5 is 1 causes exactly two further reads. Pass is reported if bit 6 is equal in those two reads; otherwise fail is reported.
- R8: If `MAX_POLLS` reads in the main loop reach neither a decision nor a bit-5 flag, the operation ends with fail after exactly `MAX_POLLS` reads.
- R9: `done` is high for exactly one cycle per operation, together with exactly one of `pass` or `fail`. Neither `pass` nor `fail` is ever high without `done`.
- R10: A `start` pulse while an operation is in progress is ignored: the address in use and the outcome do not change.
- R11: Only bit 7 of the expected byte and bits 7, 6 and 5 of the status byte influence the outcome; all other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch pulse |
| poll_mode | input | 1 | 0 = data-compare on bit 7, 1 = toggle on bit 6 |
| verify_addr | input | ADDR_W | Address to poll, captured on start |
| expect_byte | input | DATA_W | Expected byte, captured on start |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Address of the requested read |
| rd_ack | input | 1 | Read completion, one cycle |
| rd_data | input | DATA_W | Status byte, valid with rd_ack |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation succeeded (with done) |
| fail | output | 1 | Operation failed (with done) |

## Verification
A wrong state or a wrong transition shows up at the ports as a read count that does not match the expected one. If the recheck is skipped, a recheck is added, or a toggle reference is lost, the number of acknowledged reads before `done` changes. A failure can also show as the wrong verdict, which is visible in the cycle right after the deciding acknowledge. A corrupted captured address appears on `rd_addr` at the very next read, and a stuck REPORT state shows as `done` held for a second cycle.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_POLL    = 3'd1,
        ST_RECHK_A = 3'd2,
        ST_RECHK_B = 3'd3,
        ST_REPORT  = 3'd4
    } fpoll_state_t;

    typedef enum logic {
        MODE_DATA   = 1'b0,
        MODE_TOGGLE = 1'b1
    } fpoll_mode_t;

    localparam int BIT_DATA   = 7;
    localparam int BIT_TOGGLE = 6;
    localparam int BIT_LIMIT  = 5;
endpackage

// File: rtl/fpoll_eval.sv
module fpoll_eval
    import fpoll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  fpoll_mode_t       mode,
    input  logic [DATA_W-1:0] status,
    input  logic              exp_bit,
    input  logic              ref_bit,
    output logic              settled,
    output logic              limit_flag,
    output logic              tog_bit
);
    always_comb begin
        tog_bit    = status[BIT_TOGGLE];
        limit_flag = status[BIT_LIMIT];
        unique case (mode)
            MODE_DATA:   settled = (status[BIT_DATA] == exp_bit);
            MODE_TOGGLE: settled = (status[BIT_TOGGLE] == ref_bit);
            default:     settled = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpoll_budget.sv
module fpoll_budget #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int CNT_W = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step && cnt != LAST_VAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == LAST_VAL);

    // R8: the poll count never runs past the budget
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt <= LAST_VAL));
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
    import fpoll_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              poll_mode,
    input  logic [ADDR_W-1:0] verify_addr,
    input  logic [DATA_W-1:0] expect_byte,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    fpoll_state_t      state, state_nx;
    fpoll_mode_t       mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic              exp_q;
    logic              ref_q;
    logic              have_ref;
    logic              verdict;

    logic settled, limit_flag, tog_bit, last;
    logic poll_ack;
    logic win, lose, go_rechk;

    fpoll_eval #(.DATA_W(DATA_W)) u_eval (
        .mode       (mode_q),
        .status     (rd_data),
        .exp_bit    (exp_q),
        .ref_bit    (ref_q),
        .settled    (settled),
        .limit_flag (limit_flag),
        .tog_bit    (tog_bit)
    );

    assign poll_ack = (state == ST_POLL) && rd_ack;

    fpoll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_IDLE),
        .step  (poll_ack),
        .last  (last)
    );

    // decision terms for the main loop
    always_comb begin
        win      = 1'b0;
        go_rechk = 1'b0;
        lose     = 1'b0;
        if (poll_ack) begin
            if (settled && (mode_q == MODE_DATA || have_ref)) begin
                win = 1'b1;
            end else if (limit_flag && (mode_q == MODE_DATA || have_ref)) begin
                go_rechk = 1'b1;
            end else if (last) begin
                lose = 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_POLL;
            ST_POLL: begin
                if (win || lose)   state_nx = ST_REPORT;
                else if (go_rechk) state_nx = ST_RECHK_A;
            end
            ST_RECHK_A: if (rd_ack) state_nx = (mode_q == MODE_DATA) ? ST_REPORT : ST_RECHK_B;
            ST_RECHK_B: if (rd_ack) state_nx = ST_REPORT;
            ST_REPORT:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_DATA;
            addr_q   <= '0;
            exp_q    <= 1'b0;
            ref_q    <= 1'b0;
            have_ref <= 1'b0;
            verdict  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q   <= fpoll_mode_t'(poll_mode);
                        addr_q   <= verify_addr;
                        exp_q    <= expect_byte[BIT_DATA];
                        have_ref <= 1'b0;
                    end
                end
                ST_POLL: begin
                    if (rd_ack) begin
                        ref_q    <= tog_bit;
                        have_ref <= 1'b1;
                        verdict  <= win;
                    end
                end
                ST_RECHK_A: begin
                    if (rd_ack) begin
                        ref_q   <= tog_bit;
                        verdict <= settled;
                    end
                end
                ST_RECHK_B: begin
                    if (rd_ack) verdict <= settled;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_req  = (state == ST_POLL) || (state == ST_RECHK_A) || (state == ST_RECHK_B);
        rd_addr = addr_q;
        done    = (state == ST_REPORT);
        pass    = done && verdict;
        fail    = done && !verdict;
    end

    // R9: exactly one verdict accompanies done
    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({pass, fail}) == 1));
    // R9: done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: no verdict outside done
    a_r9_verdict_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pass || fail) |-> done);
    // R2: address is held across an outstanding or repeated read
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req)) |-> $stable(rd_addr));
    // R3: a result always follows an acknowledged read
    a_r3_report_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_ack));
    // R10: a start during an operation does not restart it
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && start) |=> (rd_req || done));
endmodule

// File: tb/tb_flash_status_poller.sv
`timescale 1ns/1ps
module tb_flash_status_poller;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int MP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          poll_mode = 1'b0;
    logic [AW-1:0] verify_addr = '0;
    logic [DW-1:0] expect_byte = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          done, pass, fail;

    int total = 0;
    int bad = 0;
    logic [7:0] resp [0:31];

    always #2.5 clk = ~clk;

    flash_status_poller #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_mode(poll_mode),
        .verify_addr(verify_addr), .expect_byte(expect_byte),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .done(done), .pass(pass), .fail(fail)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // runs one operation; returns verdict and read count
    task automatic run_op(input logic tmode, input logic [7:0] expb, input logic [AW-1:0] addr,
                          input bit inject, output int vpass, output int vfail, output int reads);
        int  cyc;
        bit  got;
        bit  addr_ok;
        vpass = 0; vfail = 0; reads = 0; got = 0; addr_ok = 1; cyc = 0;
        @(negedge clk);
        start = 1'b1; poll_mode = tmode; expect_byte = expb; verify_addr = addr;
        @(negedge clk);
        start = 1'b0;
        check("R2 rd_req after start", int'(rd_req), 1);
        while (!got && cyc < 200) begin
            if (start) begin start = 1'b0; verify_addr = addr; end
            if (inject && cyc == 3) begin
                start = 1'b1; verify_addr = addr ^ {AW{1'b1}}; poll_mode = ~tmode;
            end
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (rd_addr != addr) addr_ok = 0;
                rd_ack = 1'b1; rd_data = resp[reads]; reads++;
            end
            @(negedge clk);
            if (done) begin
                got = 1; vpass = int'(pass); vfail = int'(fail);
                check("R9 one verdict", int'(pass) + int'(fail), 1);
            end
            cyc++;
        end
        start = 1'b0; rd_ack = 1'b0;
        check("R2 address held", int'(addr_ok), 1);
        check("R9 done seen", int'(got), 1);
        @(negedge clk);
        check("R9 done single cycle", int'(done), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 rd_req", int'(rd_req), 0);
        check("R1 done", int'(done), 0);
        check("R1 pass/fail", int'(pass | fail), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_data_first();
        int p, f, n;
        resp[0] = 8'h80;
        run_op(1'b0, 8'hFF, 17'h01234, 0, p, f, n);
        check("R3 pass", p, 1); check("R3 reads", n, 1);
    endtask

    task automatic t_data_retry();
        int p, f, n;
        resp[0] = 8'h00; resp[1] = 8'h00; resp[2] = 8'h80;
        run_op(1'b0, 8'h80, 17'h04000, 0, p, f, n);
        check("R4 pass", p, 1); check("R4 reads", n, 3);
    endtask

    task automatic t_data_limit_ok();
        int p, f, n;
        resp[0] = 8'h20; resp[1] = 8'h80;
        run_op(1'b0, 8'h80, 17'h10000, 0, p, f, n);
        check("R5 pass after recheck", p, 1); check("R5 reads", n, 2);
    endtask

    task automatic t_data_limit_bad();
        int p, f, n;
        resp[0] = 8'h20; resp[1] = 8'h20; resp[2] = 8'h80;
        run_op(1'b0, 8'h80, 17'h1C000, 0, p, f, n);
        check("R5 fail after recheck", f, 1); check("R5 reads", n, 2);
    endtask

    task automatic t_data_program_zero();
        int p, f, n;
        resp[0] = 8'hB5; resp[1] = 8'h35;
        run_op(1'b0, 8'h35, 17'h00F0F, 0, p, f, n);
        check("R3 bit7=0 pass", p, 1); check("R4 reads", n, 2);
    endtask

    task automatic t_tog_pass();
        int p, f, n;
        resp[0] = 8'h40; resp[1] = 8'h00; resp[2] = 8'h00;
        run_op(1'b1, 8'hFF, 17'h02000, 0, p, f, n);
        check("R6 pass", p, 1); check("R6 reads", n, 3);
    endtask

    task automatic t_tog_limit_ok();
        int p, f, n;
        resp[0] = 8'h00; resp[1] = 8'h60; resp[2] = 8'h40; resp[3] = 8'h40;
        run_op(1'b1, 8'hFF, 17'h08000, 0, p, f, n);
        check("R7 pass", p, 1); check("R7 reads", n, 4);
    endtask

    task automatic t_tog_limit_bad();
        int p, f, n;
        resp[0] = 8'h00; resp[1] = 8'h60; resp[2] = 8'h20; resp[3] = 8'h60; resp[4] = 8'h60;
        run_op(1'b1, 8'hFF, 17'h0C000, 0, p, f, n);
        check("R7 fail", f, 1); check("R7 reads", n, 4);
    endtask

    task automatic t_budget_data();
        int p, f, n;
        for (int i = 0; i < 16; i++) resp[i] = 8'h00;
        run_op(1'b0, 8'h80, 17'h00010, 0, p, f, n);
        check("R8 data fail", f, 1); check("R8 data reads", n, MP);
    endtask

    task automatic t_budget_tog();
        int p, f, n;
        for (int i = 0; i < 16; i++) resp[i] = (i % 2 == 0) ? 8'h00 : 8'h40;
        run_op(1'b1, 8'hFF, 17'h00020, 0, p, f, n);
        check("R8 toggle fail", f, 1); check("R8 toggle reads", n, MP);
    endtask

    task automatic t_busy_start();
        int p, f, n;
        resp[0] = 8'h00; resp[1] = 8'h00; resp[2] = 8'h00; resp[3] = 8'h80;
        run_op(1'b0, 8'h80, 17'h0AAAA, 1, p, f, n);
        check("R10 pass kept", p, 1); check("R10 reads", n, 4);
    endtask

    task automatic t_ignored_bits();
        int p, f, n;
        resp[0] = 8'hDF;
        run_op(1'b0, 8'h80, 17'h00001, 0, p, f, n);
        check("R11 data low bits", p, 1); check("R11 data reads", n, 1);
        resp[0] = 8'h00; resp[1] = 8'h1F;
        run_op(1'b1, 8'h00, 17'h00002, 0, p, f, n);
        check("R11 toggle low bits", p, 1); check("R11 toggle reads", n, 2);
    endtask

    initial begin
        #(200000 * 5.0);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_data_first();
        t_data_retry();
        t_data_limit_ok();
        t_data_limit_bad();
        t_data_program_zero();
        t_tog_pass();
        t_tog_limit_ok();
        t_tog_limit_bad();
        t_budget_data();
        t_budget_tog();
        t_busy_start();
        t_ignored_bits();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule